// File: doc/BRIEF.md
# ADC Multiplexer Conversion Sequencer

This block runs the input multiplexer in front of a decimating converter. It visits seven measurement channels in a fixed order. For each channel it issues a start pulse to the decimation filter and waits for the filter's done strobe. It then writes the filter result into a small result RAM, at an address that belongs to that channel. The slow reference clock reaches the block as a one-cycle strobe (`slow_tick`) in the system clock domain. Every change of multiplexer state lines up with that strobe.

After the filter reports done, the sequencer holds until a later tick before it moves to the next channel. A length field sets the minimum number of reference periods that each conversion occupies. A two-bit chopper field selects a fixed polarity, or a polarity that flips once per full pass over the channel list. Flipping between passes lets DC offsets cancel over pairs of passes. The filter arithmetic, the modulator and the amplifier are not part of this block.

Top module: `adc_mux_seq`

## Requirements
- R1: While reset is held and after it is released, `fir_start` and `ram_we` are 0 and `mux_sel` is 0. No conversion starts until a `slow_tick` is seen.
- R2: The first `slow_tick` after reset starts channel 0. `fir_start` is high for exactly one system cycle, the cycle after the tick cycle.
- R3: The channel index on `mux_sel` runs 0,1,2,3,4,5,6 and then wraps to 0. The channels are current A, voltage B, current B, voltage A, auxiliary, temperature and battery, in that order.
- R4: A done strobe during a conversion gives `ram_we` high for exactly one cycle, in the cycle after the done. The address is fixed per channel: indices 0..3 go to 0x00..0x03, and indices 4, 5, 6 go to 0x09, 0x0A, 0x0B.
- R5: `ram_wdata` is `fir_data` placed eight bit positions up, with the low eight bits zero.
- R6: After done, the next conversion starts only on a `slow_tick`. Its `fir_start` comes in the cycle after that tick, and no start is issued on any other cycle.
- R7: With length field L (0, 1 or 2; the value 3 acts as 2), suppose done comes after k ticks of the current conversion. The next conversion then starts on tick number max(k+1, L+1) counted from its start.
- R8: A done strobe while the sequencer holds after an accepted done produces no RAM write.
- R9: Chopper field 00 drives `chop_pol` to 0 and 01 drives it to 1. Field 1x drives it from the internal toggle bit.
- R10: The toggle bit starts at 0 and flips only when the sequence wraps from channel 6 to channel 0, never inside a pass.
- R11: Asserting `rst_n` low in the middle of a conversion returns the block at once to idle, with the toggle bit at 0. The next tick after release restarts at channel 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_tick | input | 1 | One-cycle strobe marking each reference-clock rising edge |
| len_sel | input | 2 | Conversion length field (reference periods minus one) |
| chop_mode | input | 2 | Chopper polarity control |
| fir_done | input | 1 | Filter conversion-complete strobe |
| fir_data | input | 16 | Filter result, LSB-justified |
| fir_start | output | 1 | One-cycle conversion start to the filter |
| mux_sel | output | 3 | Current channel index |
| ram_we | output | 1 | Result RAM write enable |
| ram_addr | output | 8 | Result RAM address |
| ram_wdata | output | 24 | Result RAM write data |
| chop_pol | output | 1 | Reference amplifier polarity |

## Verification
The bench sweeps all length values, including the aliased value 3, against done arriving before the first tick, after one tick and after two ticks. A sequencer that advanced on done alone, or that ignored the length field, would issue `fir_start` on the wrong tick. Each pass checks the address jump between index 3 and index 4 and the position of the result in the data word. It also sends a stray done while the sequencer holds; a design that accepted it would overwrite the stored result. The chopper modes are changed between passes so that the toggle bit is seen flipping only at wraps, and a reset in the middle of a run checks that the toggle bit and the channel both clear.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_t;

  localparam int SEQ_NUM_CH    = 7;
  localparam int LOW_GROUP_CNT = 4;
  localparam int HIGH_GROUP_BASE = 9;

  // channel index to result slot: first group packed from zero, second group offset
  function automatic int slot_of(input int idx);
    if (idx < LOW_GROUP_CNT) return idx;
    else return idx - LOW_GROUP_CNT + HIGH_GROUP_BASE;
  endfunction

endpackage

// File: rtl/adc_seq_rst.sv
module adc_seq_rst (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH  = 7,
  parameter int CH_W    = 3,
  parameter int LEN_W   = 2,
  parameter int MAX_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic [LEN_W-1:0] len_sel,
  input  logic             fir_done,
  output logic [CH_W-1:0]  chan_o,
  output logic             start_o,
  output logic             wrap_o,
  output logic             accept_o
);

  localparam int CNT_W = LEN_W;
  localparam logic [CH_W-1:0]  LAST_CH = CH_W'(NUM_CH - 1);
  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  seq_state_t       state_q, state_d;
  logic [CH_W-1:0]  chan_q, chan_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             start_q, start_d;
  logic             chan_en, cnt_en;
  logic [LEN_W-1:0] len_eff;

  assign len_eff = (len_sel > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : len_sel;

  always_comb begin
    state_d  = state_q;
    chan_d   = chan_q;
    cnt_d    = cnt_q;
    start_d  = 1'b0;
    chan_en  = 1'b0;
    cnt_en   = 1'b0;
    wrap_o   = 1'b0;
    accept_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (slow_tick) begin
          state_d = ST_CONV;
          chan_d  = '0;
          chan_en = 1'b1;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          start_d = 1'b1;
        end
      end
      ST_CONV: begin
        if (slow_tick && (cnt_q != CNT_SAT)) begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
        if (fir_done) begin
          state_d  = ST_HOLD;
          accept_o = 1'b1;
        end
      end
      ST_HOLD: begin
        if (slow_tick) begin
          if (cnt_q >= CNT_W'(len_eff)) begin
            state_d = ST_CONV;
            chan_en = 1'b1;
            cnt_d   = '0;
            cnt_en  = 1'b1;
            start_d = 1'b1;
            if (chan_q == LAST_CH) begin
              chan_d = '0;
              wrap_o = 1'b1;
            end else begin
              chan_d = chan_q + 1'b1;
            end
          end else if (cnt_q != CNT_SAT) begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      cnt_q   <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      if (chan_en) chan_q <= chan_d;
      if (cnt_en)  cnt_q  <= cnt_d;
    end
  end

  assign chan_o  = chan_q;
  assign start_o = start_q;

endmodule

// File: rtl/adc_seq_wr.sv
module adc_seq_wr
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int CH_W   = 3,
  parameter int DATA_W = 16,
  parameter int SHIFT  = 8,
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [CH_W-1:0]         chan,
  input  logic [DATA_W-1:0]       fir_data,
  output logic                    ram_we,
  output logic [ADDR_W-1:0]       ram_addr,
  output logic [DATA_W+SHIFT-1:0] ram_wdata
);

  localparam int SLOTS = 1 << CH_W;
  localparam int WD_W  = DATA_W + SHIFT;

  logic [ADDR_W-1:0] slot_rom [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_CH) begin : g_used
      assign slot_rom[g] = ADDR_W'(slot_of(g));
    end else begin : g_spare
      assign slot_rom[g] = '0;
    end
  end

  logic              we_q, we_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WD_W-1:0]   data_q, data_d;

  always_comb begin
    we_d   = accept;
    addr_d = slot_rom[chan];
    data_d = {fir_data, {SHIFT{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= we_d;
      if (accept) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end

  assign ram_we    = we_q;
  assign ram_addr  = addr_q;
  assign ram_wdata = data_q;

endmodule

// File: rtl/adc_seq_chop.sv
module adc_seq_chop (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap,
  input  logic [1:0] mode,
  output logic       chop_pol
);

  logic tog_q, tog_d;

  always_comb begin
    tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
    end else if (wrap) begin
      tog_q <= tog_d;
    end
  end

  // mode[1] set: follow the per-pass toggle; otherwise mode[0] is a fixed polarity
  assign chop_pol = mode[1] ? tog_q : mode[0];

endmodule

// File: rtl/adc_mux_seq.sv
module adc_mux_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 8,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    slow_tick,
  input  logic [LEN_W-1:0]        len_sel,
  input  logic [1:0]              chop_mode,
  input  logic                    fir_done,
  input  logic [DATA_W-1:0]       fir_data,
  output logic                    fir_start,
  output logic [2:0]              mux_sel,
  output logic                    ram_we,
  output logic [ADDR_W-1:0]       ram_addr,
  output logic [DATA_W+SHIFT-1:0] ram_wdata,
  output logic                    chop_pol
);

  localparam int NUM_CH  = SEQ_NUM_CH;
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int MAX_LEN = 2;

  logic            rst_sync_n;
  logic [CH_W-1:0] chan;
  logic            wrap;
  logic            accept;

  adc_seq_rst u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adc_seq_fsm #(
    .NUM_CH  (NUM_CH),
    .CH_W    (CH_W),
    .LEN_W   (LEN_W),
    .MAX_LEN (MAX_LEN)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .slow_tick (slow_tick),
    .len_sel   (len_sel),
    .fir_done  (fir_done),
    .chan_o    (chan),
    .start_o   (fir_start),
    .wrap_o    (wrap),
    .accept_o  (accept)
  );

  adc_seq_wr #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .DATA_W (DATA_W),
    .SHIFT  (SHIFT),
    .ADDR_W (ADDR_W)
  ) u_wr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .chan      (chan),
    .fir_data  (fir_data),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata)
  );

  adc_seq_chop u_chop (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wrap     (wrap),
    .mode     (chop_mode),
    .chop_pol (chop_pol)
  );

  assign mux_sel = 3'(chan);

endmodule

// File: rtl/adc_mux_seq_chk.sv
module adc_mux_seq_chk #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 8,
  parameter int ADDR_W = 8,
  parameter int LEN_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    slow_tick,
  input logic [LEN_W-1:0]        len_sel,
  input logic [1:0]              chop_mode,
  input logic                    fir_done,
  input logic [DATA_W-1:0]       fir_data,
  input logic                    fir_start,
  input logic [2:0]              mux_sel,
  input logic                    ram_we,
  input logic [ADDR_W-1:0]       ram_addr,
  input logic [DATA_W+SHIFT-1:0] ram_wdata,
  input logic                    chop_pol
);

  localparam int WD_W = DATA_W + SHIFT;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fir_start |=> !fir_start); // R2

  AST_START_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    fir_start |-> $past(slow_tick)); // R6

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we); // R4

  AST_WE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(fir_done)); // R4

  AST_SLOT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (int'(ram_addr) == ((int'(mux_sel) < 4) ? int'(mux_sel) : int'(mux_sel) + 5))); // R4

  AST_DATA_SHIFTED: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_wdata == (WD_W'($past(fir_data)) << SHIFT))); // R5

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mux_sel < 3'd7); // R3

  AST_CHOP_PASS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(chop_mode) && !(fir_start && mux_sel == 3'd0)) |-> $stable(chop_pol)); // R10

endmodule

bind adc_mux_seq adc_mux_seq_chk #(
  .DATA_W (DATA_W),
  .SHIFT  (SHIFT),
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W)
) i_chk (.*);

// File: tb/test_adc_mux_seq.sv
module test_adc_mux_seq;

  logic        clk;
  logic        rst_n;
  logic        slow_tick;
  logic [1:0]  len_sel;
  logic [1:0]  chop_mode;
  logic        fir_done;
  logic [15:0] fir_data;
  logic        fir_start;
  logic [2:0]  mux_sel;
  logic        ram_we;
  logic [7:0]  ram_addr;
  logic [23:0] ram_wdata;
  logic        chop_pol;

  int tests;
  int fails;
  int wraps;

  adc_mux_seq i_adc_mux_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick),
    .len_sel   (len_sel),
    .chop_mode (chop_mode),
    .fir_done  (fir_done),
    .fir_data  (fir_data),
    .fir_start (fir_start),
    .mux_sel   (mux_sel),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .chop_pol  (chop_pol)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slot(input int ch);
    return (ch < 4) ? ch : ch + 5;
  endfunction

  function automatic bit exp_chop(input logic [1:0] m, input int w);
    return m[1] ? bit'(w % 2) : m[0];
  endfunction

  // one tick; exp_start says whether a new conversion must begin from it
  task automatic tick_chk(input bit exp_start, input int exp_ch, input string req);
    @(negedge clk) slow_tick = 1'b1;
    @(negedge clk) slow_tick = 1'b0;
    chk(fir_start == exp_start, req, 32'(fir_start), 32'(exp_start));
    if (exp_start) begin
      chk(int'(mux_sel) == exp_ch, "R3", 32'(mux_sel), 32'(exp_ch));
      @(negedge clk);
      chk(fir_start == 1'b0, "R2", 32'(fir_start), 32'd0);
      repeat (1) @(negedge clk);
    end else begin
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic do_conv(input int ch, input int len, input logic [1:0] mode,
                         input int k, input logic [15:0] d, input bit poke);
    int n;
    int nxt;
    @(negedge clk);
    len_sel   = 2'(len);
    chop_mode = mode;
    #1;
    chk(int'(mux_sel) == ch, "R3", 32'(mux_sel), 32'(ch));
    chk(chop_pol == exp_chop(mode, wraps), "R9 R10", 32'(chop_pol), 32'(exp_chop(mode, wraps)));
    for (int j = 1; j <= k; j++) tick_chk(1'b0, 0, "R6");
    @(negedge clk);
    fir_done = 1'b1;
    fir_data = d;
    @(negedge clk);
    fir_done = 1'b0;
    chk(ram_we == 1'b1, "R4", 32'(ram_we), 32'd1);
    chk(int'(ram_addr) == slot(ch), "R4", 32'(ram_addr), 32'(slot(ch)));
    chk(ram_wdata == {d, 8'h00}, "R5", 32'(ram_wdata), 32'({d, 8'h00}));
    @(negedge clk);
    chk(ram_we == 1'b0, "R4", 32'(ram_we), 32'd0);
    if (poke) begin
      fir_done = 1'b1;
      fir_data = ~d;
      @(negedge clk);
      fir_done = 1'b0;
      chk(ram_we == 1'b0, "R8", 32'(ram_we), 32'd0);
    end
    n = ((len > 2) ? 2 : len) + 1;
    if (k + 1 > n) n = k + 1;
    for (int j = k + 1; j < n; j++) tick_chk(1'b0, 0, "R7");
    nxt = (ch == 6) ? 0 : ch + 1;
    if (ch == 6) wraps++;
    tick_chk(1'b1, nxt, "R7");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests     = 0;
    fails     = 0;
    wraps     = 0;
    rst_n     = 1'b0;
    slow_tick = 1'b0;
    len_sel   = 2'd0;
    chop_mode = 2'b10;
    fir_done  = 1'b0;
    fir_data  = '0;
    repeat (3) @(negedge clk);
    chk(fir_start == 1'b0 && ram_we == 1'b0, "R1", {30'd0, fir_start, ram_we}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mux_sel == 3'd0, "R1", 32'(mux_sel), 32'd0);
    chk(chop_pol == 1'b0, "R1", 32'(chop_pol), 32'd0);
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk(fir_start == 1'b0 && ram_we == 1'b0, "R1", {30'd0, fir_start, ram_we}, 32'd0);
    end
    tick_chk(1'b1, 0, "R2");

    for (int p = 0; p < 4; p++) begin
      logic [1:0] m;
      m = (p == 0) ? 2'b10 : (p == 1) ? 2'b01 : (p == 2) ? 2'b00 : 2'b11;
      for (int ch = 0; ch < 7; ch++) begin
        do_conv(ch, p, m, (ch + p) % 3,
                16'(16'hA000 + p * 16'h0111 + ch * 16'h1013), ch == 2);
      end
    end

    // R11: reset in the middle of a conversion
    @(negedge clk);
    chop_mode = 2'b10;
    tick_chk(1'b0, 0, "R6");
    @(negedge clk) rst_n = 1'b0;
    #1;
    chk(fir_start == 1'b0 && ram_we == 1'b0, "R11", {30'd0, fir_start, ram_we}, 32'd0);
    chk(mux_sel == 3'd0, "R11", 32'(mux_sel), 32'd0);
    chk(chop_pol == 1'b0, "R11", 32'(chop_pol), 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wraps = 0;
    repeat (5) @(negedge clk);
    chk(fir_start == 1'b0, "R11", 32'(fir_start), 32'd0);
    tick_chk(1'b1, 0, "R11");
    do_conv(0, 0, 2'b10, 0, 16'h1234, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule